// File: doc/BRIEF.md
# Quantization Table Reload Controller

This controller sequences a JPEG encoder core between frames. It writes a luminance and a chrominance quantization table into the core over a small register bus, where each write waits for an acknowledge. It then starts the core on each ready frame and waits for the core to report completion. Table entries come from a base ramp scaled by the active quality value, which is computed inside the block.

A full reload costs one bus transaction per entry of both tables, and every transaction waits at least one extra cycle for its acknowledge. The controller therefore reloads only when a quality command differs from the value the tables were last loaded with. Otherwise it passes from the core's done indication straight to the next start. A quality command that arrives mid-frame is held and takes effect at the next frame boundary. After reset the tables are treated as invalid and loaded once with the default quality.

Top module: `qtab_reload_ctrl`

## Requirements
- R1: After reset, `loading_o` is 1, `bus_wr_o` and `core_start_o` are 0, and a complete load of both tables at quality `DEF_QUAL` (default 50) finishes before the first `core_start_o`.
- R2: A load issues exactly 2*N_ENTRY writes. The luminance entries go to addresses 0..N_ENTRY-1 (address MSB 0), then the chrominance entries go to N_ENTRY..2*N_ENTRY-1 (address MSB 1), and each write's address is one above the previous.
- R3: `bus_wr_o` stays high with stable address and data until a rising edge samples `bus_ack_i` high. In the next cycle `bus_wr_o` is low.
- R4: `bus_ack_i` sampled while `bus_wr_o` is low has no effect on the bus, on `loading_o` or on the write count.
- R5: For quality q, clamped to 1..100, S = 5000/q when q < 50 and 200-2q otherwise. Entry i has base 8+2i (luminance) or 12+2i (chrominance), and its value is (base*S+50)/100 with integer division, clamped to 1..255. At q=100 every entry is 1; at q=1 every entry is 255.
- R6: In the waiting phase, `core_start_o` is high for exactly one cycle, following the rising edge that samples `frame_rdy_i` high with no differing quality pending. No start occurs while `frame_rdy_i` is low.
- R7: With `frame_rdy_i` held high and no differing quality pending, the next `core_start_o` follows `core_done_i` after one idle cycle, with no bus write in between.
- R8: A quality strobe during a load or an encode is held and applied at the next frame boundary. If several strobes arrive, the last one wins, and a strobe during a load causes a second load before the next start.
- R9: A strobed quality equal to the loaded quality triggers no reload.
- R10: `loading_o` is high exactly during the load phase. Every write falls inside it, and no start does.
- R11: A strobe sampled on the same edge as `core_done_i` causes a reload before the next start. A strobe sampled on the edge that takes the start decision takes effect only at the following boundary.
- R12: `core_done_i` outside an encode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qual_i | input | QUAL_W | Commanded encoding quality |
| qual_chg_i | input | 1 | Strobe: capture `qual_i` as a new command |
| frame_rdy_i | input | 1 | A frame is ready to encode |
| core_done_i | input | 1 | Encoder core finished the frame |
| bus_ack_i | input | 1 | Register bus write acknowledge |
| bus_wr_o | output | 1 | Register bus write request |
| bus_addr_o | output | log2(N_ENTRY)+1 | Table write address, MSB selects chrominance |
| bus_data_o | output | DATA_W | Table entry value |
| core_start_o | output | 1 | One-cycle frame start to the core |
| loading_o | output | 1 | High while tables are being written |

## Verification
Two events can meet at the frame boundary. A quality strobe can coincide with the core's done indication, or it can coincide with the waiting-phase edge that decides whether to start. The bench injects the strobe from its core responder in exactly one of those two cycles. A cycle-accurate behavioural model then decides whether a reload precedes the next start or is deferred by one frame, and it checks every bus beat and start pulse against that decision. Strobes that land inside a load, and acknowledges or done pulses that arrive outside their phase, are judged the same way.

// File: rtl/qtr_pkg.sv
package qtr_pkg;
   typedef enum logic [2:0] {
      ST_INIT  = 3'd0,
      ST_REQ   = 3'd1,
      ST_GAP   = 3'd2,
      ST_WAIT  = 3'd3,
      ST_START = 3'd4,
      ST_ENC   = 3'd5
   } qtr_state_e;
endpackage

// File: rtl/qtr_rom.sv
module qtr_rom #(
   parameter int unsigned N_ENTRY   = 64,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned QUAL_W    = 7,
   parameter int unsigned LUM_BASE  = 8,
   parameter int unsigned CHR_BASE  = 12,
   parameter int unsigned BASE_STEP = 2,
   localparam int unsigned IDX_W    = $clog2(N_ENTRY)
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              tbl_i,
   input  logic [QUAL_W-1:0] qual_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int unsigned MAXV = (1 << DATA_W) - 1;

   int unsigned qc;
   int unsigned scale;

   always_comb begin
      qc = 32'(qual_i);
      if (qc == 0)  qc = 1;
      if (qc > 100) qc = 100;
      if (qc < 50) scale = 5000 / qc;
      else         scale = 200 - 2 * qc;
   end

   for (genvar t = 0; t < 2; t++) begin : g_tbl
      localparam int unsigned BASE = (t == 0) ? LUM_BASE : CHR_BASE;
      int unsigned v;
      logic [DATA_W-1:0] ent;
      always_comb begin
         v = (BASE + BASE_STEP * 32'(idx_i)) * scale + 50;
         v = v / 100;
         if (v == 0)   v = 1;
         if (v > MAXV) v = MAXV;
         ent = DATA_W'(v);
      end
   end

   assign data_o = tbl_i ? g_tbl[1].ent : g_tbl[0].ent;
endmodule

// File: rtl/qtr_qual_latch.sv
module qtr_qual_latch #(
   parameter int unsigned QUAL_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg_i,
   input  logic [QUAL_W-1:0] qual_i,
   input  logic              consume_i,
   output logic              pend_v_o,
   output logic [QUAL_W-1:0] pend_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v_o <= 1'b0;
         pend_q_o <= '0;
      end else if (chg_i) begin
         pend_v_o <= 1'b1;
         pend_q_o <= qual_i;
      end else if (consume_i) begin
         pend_v_o <= 1'b0;
      end
   end
endmodule

// File: rtl/qtr_fsm.sv
module qtr_fsm
   import qtr_pkg::*;
#(
   parameter int unsigned N_ENTRY  = 64,
   parameter int unsigned QUAL_W   = 7,
   parameter int unsigned DEF_QUAL = 50,
   localparam int unsigned CNT_W   = $clog2(N_ENTRY) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_i,
   input  logic              frame_rdy_i,
   input  logic              done_i,
   input  logic              pend_v_i,
   input  logic [QUAL_W-1:0] pend_q_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [QUAL_W-1:0] act_q_o,
   output logic              consume_o,
   output logic              wr_o,
   output logic              start_o,
   output logic              loading_o
);
   qtr_state_e st;
   logic       reload;

   assign consume_o = (st == ST_WAIT) && pend_v_i;
   assign reload    = consume_o && (pend_q_i != act_q_o);
   assign wr_o      = (st == ST_REQ);
   assign start_o   = (st == ST_START);
   assign loading_o = (st == ST_INIT) || (st == ST_REQ) || (st == ST_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_INIT;
         cnt_o   <= '0;
         act_q_o <= QUAL_W'(DEF_QUAL);
      end else begin
         unique case (st)
            ST_INIT:  st <= ST_REQ;
            ST_REQ: begin
               if (ack_i) begin
                  cnt_o <= cnt_o + 1'b1;
                  st    <= ST_GAP;
               end
            end
            ST_GAP:   st <= (cnt_o == '0) ? ST_WAIT : ST_REQ;
            ST_WAIT: begin
               if (reload) begin
                  act_q_o <= pend_q_i;
                  st      <= ST_REQ;
               end else if (frame_rdy_i) begin
                  st <= ST_START;
               end
            end
            ST_START: st <= ST_ENC;
            ST_ENC:   if (done_i) st <= ST_WAIT;
            default:  st <= ST_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/qtab_reload_ctrl.sv
module qtab_reload_ctrl #(
   parameter int unsigned N_ENTRY   = 64,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned QUAL_W    = 7,
   parameter int unsigned DEF_QUAL  = 50,
   parameter int unsigned LUM_BASE  = 8,
   parameter int unsigned CHR_BASE  = 12,
   parameter int unsigned BASE_STEP = 2,
   localparam int unsigned IDX_W    = $clog2(N_ENTRY),
   localparam int unsigned ADDR_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QUAL_W-1:0] qual_i,
   input  logic              qual_chg_i,
   input  logic              frame_rdy_i,
   input  logic              core_done_i,
   input  logic              bus_ack_i,
   output logic              bus_wr_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              core_start_o,
   output logic              loading_o
);
   initial begin : p_param_chk
      assert (N_ENTRY >= 2 && (N_ENTRY & (N_ENTRY - 1)) == 0)
         else $error("N_ENTRY must be a power of two >= 2");
      assert (DATA_W >= 1 && DATA_W <= 16) else $error("DATA_W out of range");
      assert (QUAL_W >= 7 && QUAL_W <= 16) else $error("QUAL_W out of range");
      assert (DEF_QUAL >= 1 && DEF_QUAL <= 100) else $error("DEF_QUAL out of range");
   end

   logic              pend_v;
   logic [QUAL_W-1:0] pend_q;
   logic              consume;
   logic [QUAL_W-1:0] act_q;

   qtr_qual_latch #(.QUAL_W(QUAL_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .chg_i     (qual_chg_i),
      .qual_i    (qual_i),
      .consume_i (consume),
      .pend_v_o  (pend_v),
      .pend_q_o  (pend_q)
   );

   qtr_fsm #(
      .N_ENTRY  (N_ENTRY),
      .QUAL_W   (QUAL_W),
      .DEF_QUAL (DEF_QUAL)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_i       (bus_ack_i),
      .frame_rdy_i (frame_rdy_i),
      .done_i      (core_done_i),
      .pend_v_i    (pend_v),
      .pend_q_i    (pend_q),
      .cnt_o       (bus_addr_o),
      .act_q_o     (act_q),
      .consume_o   (consume),
      .wr_o        (bus_wr_o),
      .start_o     (core_start_o),
      .loading_o   (loading_o)
   );

   qtr_rom #(
      .N_ENTRY   (N_ENTRY),
      .DATA_W    (DATA_W),
      .QUAL_W    (QUAL_W),
      .LUM_BASE  (LUM_BASE),
      .CHR_BASE  (CHR_BASE),
      .BASE_STEP (BASE_STEP)
   ) u_rom (
      .idx_i  (bus_addr_o[IDX_W-1:0]),
      .tbl_i  (bus_addr_o[IDX_W]),
      .qual_i (act_q),
      .data_o (bus_data_o)
   );
endmodule

// File: rtl/qtr_chk.sv
module qtr_chk #(
   parameter int unsigned N_ENTRY = 64,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned ADDR_W = $clog2(N_ENTRY) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_o,
   input logic              bus_ack_i,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [DATA_W-1:0] bus_data_o,
   input logic              core_start_o,
   input logic              loading_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(2 * N_ENTRY - 1);

   logic loaded;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) loaded <= 1'b0;
      else if (bus_wr_o && bus_ack_i && bus_addr_o == LAST) loaded <= 1'b1;
   end

   a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o && !bus_ack_i |=> bus_wr_o && $stable(bus_addr_o) && $stable(bus_data_o));

   a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o && bus_ack_i |=> !bus_wr_o);

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o && bus_ack_i && bus_addr_o != LAST |=> ##1
         (bus_wr_o && bus_addr_o == ADDR_W'($past(bus_addr_o, 2) + 1'b1)));

   a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |=> !core_start_o);

   a_r10_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |-> loading_o);

   a_r10_no_start_in_load: assert property (@(posedge clk) disable iff (!rst_n)
      loading_o |-> !core_start_o);

   a_r1_load_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |-> loaded);
endmodule

bind qtab_reload_ctrl qtr_chk #(.N_ENTRY(N_ENTRY), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr_o     (bus_wr_o),
   .bus_ack_i    (bus_ack_i),
   .bus_addr_o   (bus_addr_o),
   .bus_data_o   (bus_data_o),
   .core_start_o (core_start_o),
   .loading_o    (loading_o)
);

// File: tb/qtab_reload_ctrl_tb_top.sv
module qtab_reload_ctrl_tb_top;
   localparam int N  = 64;
   localparam int NW = 2 * N;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [6:0] qual_i = 7'd50;
   logic       qual_chg_i = 1'b0, frame_rdy_i = 1'b0, core_done_i = 1'b0, bus_ack_i = 1'b0;
   logic       bus_wr_o, core_start_o, loading_o;
   logic [6:0] bus_addr_o;
   logic [7:0] bus_data_o;

   qtab_reload_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .qual_i(qual_i), .qual_chg_i(qual_chg_i),
      .frame_rdy_i(frame_rdy_i), .core_done_i(core_done_i), .bus_ack_i(bus_ack_i),
      .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
      .core_start_o(core_start_o), .loading_o(loading_o)
   );

   int chk_total = 0, chk_fail = 0, cyc = 0;
   bit fin = 0;
   int ack_lat = 2, ack_cnt = 0, enc_len = 20, enc_cnt = 0;
   int writes = 0, starts = 0, dmin = 999, dmax = 0;
   bit spur_ack = 0, spur_done_load = 0, auto_chg = 0;
   int co_mode = 0, co_val = 0;
   int w0;

   // behavioural reference: phase 5 init, 0 request, 1 gap, 2 wait, 3 start, 4 encode
   int m_ph = 5, m_n = 0, m_act = 50, m_pq = 0;
   bit m_pv = 0, m_cons = 0;

   function automatic int qexp(int tb, int i, int q);
      int qq, s, v;
      qq = q;
      if (qq < 1)   qq = 1;
      if (qq > 100) qq = 100;
      s = (qq < 50) ? 5000 / qq : 200 - 2 * qq;
      v = (((tb != 0) ? 12 : 8) + 2 * i) * s;
      v = (v + 50) / 100;
      if (v < 1)   v = 1;
      if (v > 255) v = 255;
      return v;
   endfunction

   task automatic chk(string tag, bit ok, int act, int exp, string what);
      chk_total++;
      if (!ok) begin
         chk_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", chk_total - chk_fail, chk_total);
      $finish;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 5; m_n = 0; m_act = 50; m_pv = 0; m_pq = 0;
      end else begin
         m_cons = 0;
         case (m_ph)
            5: m_ph = 0;
            0: if (bus_ack_i) begin m_n = (m_n + 1) % NW; m_ph = 1; end
            1: m_ph = (m_n == 0) ? 2 : 0;
            2: begin
               m_cons = m_pv;
               if (m_pv && m_pq != m_act) begin m_act = m_pq; m_ph = 0; end
               else if (frame_rdy_i) m_ph = 3;
            end
            3: m_ph = 4;
            4: if (core_done_i) m_ph = 2;
            default: ;
         endcase
         if (qual_chg_i) begin m_pv = 1; m_pq = int'(qual_i); end
         else if (m_cons) m_pv = 0;
      end
   end

   always @(negedge clk) begin
      cyc++;
      // per-cycle comparison against the reference
      chk("R3", bus_wr_o == (m_ph == 0), int'(bus_wr_o), int'(m_ph == 0), "bus_wr_o");
      chk("R10", loading_o == (m_ph == 0 || m_ph == 1 || m_ph == 5), int'(loading_o),
          int'(m_ph == 0 || m_ph == 1 || m_ph == 5), "loading_o");
      chk("R6", core_start_o == (m_ph == 3), int'(core_start_o), int'(m_ph == 3), "core_start_o");
      if (m_ph == 0) begin
         chk("R2", int'(bus_addr_o) == m_n, int'(bus_addr_o), m_n, "bus_addr_o");
         chk("R5", int'(bus_data_o) == qexp(m_n / N, m_n % N, m_act), int'(bus_data_o),
             qexp(m_n / N, m_n % N, m_act), "bus_data_o");
      end
      // bus acknowledge responder
      if (bus_ack_i) bus_ack_i = 1'b0;
      else if (bus_wr_o) begin
         ack_cnt++;
         if (ack_cnt >= ack_lat) begin
            bus_ack_i = 1'b1; ack_cnt = 0; writes++;
            if (int'(bus_data_o) < dmin) dmin = int'(bus_data_o);
            if (int'(bus_data_o) > dmax) dmax = int'(bus_data_o);
         end
      end else if (spur_ack) begin
         bus_ack_i = 1'b1; spur_ack = 0;
      end
      // core responder, with optional coincident quality strobes
      if (auto_chg) begin qual_chg_i = 1'b0; auto_chg = 0; end
      if (core_done_i) begin
         core_done_i = 1'b0;
         if (co_mode == 2) begin qual_chg_i = 1'b1; qual_i = 7'(co_val); auto_chg = 1; co_mode = 0; end
      end else if (core_start_o) begin
         enc_cnt = enc_len; starts++;
      end else if (enc_cnt > 0) begin
         enc_cnt--;
         if (enc_cnt == 0) begin
            core_done_i = 1'b1;
            if (co_mode == 1) begin qual_chg_i = 1'b1; qual_i = 7'(co_val); auto_chg = 1; co_mode = 0; end
         end
      end else if (spur_done_load && loading_o) begin
         core_done_i = 1'b1; spur_done_load = 0;
      end
      if (cyc > 150000 && !fin) begin
         fin = 1;
         chk("R6", 1'b0, cyc, 150000, "watchdog expired");
         report();
      end
   end

   task automatic run_frames(int n);
      int s0;
      s0 = starts;
      while (starts < s0 + n) @(negedge clk);
   endtask

   task automatic strobe(int v);
      qual_chg_i = 1'b1; qual_i = 7'(v);
      @(negedge clk);
      qual_chg_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", loading_o == 1'b1, int'(loading_o), 1, "reset loading_o");
      chk("R1", bus_wr_o == 1'b0, int'(bus_wr_o), 0, "reset bus_wr_o");
      chk("R1", core_start_o == 1'b0, int'(core_start_o), 0, "reset core_start_o");
      rst_n = 1'b1;
      do @(negedge clk); while (loading_o);
      chk("R1", writes == NW, writes, NW, "writes in initial load");
      chk("R6", starts == 0, starts, 0, "starts while frame_rdy_i low");
      // R4: stray acknowledge while idle
      spur_ack = 1;
      repeat (6) @(negedge clk);
      chk("R4", writes == NW, writes, NW, "writes after stray ack");
      chk("R4", loading_o == 1'b0, int'(loading_o), 0, "loading_o after stray ack");
      // R7: back-to-back frames skip the reload
      frame_rdy_i = 1'b1;
      w0 = writes;
      run_frames(3);
      chk("R7", writes == w0, writes - w0, 0, "writes across unchanged frames");
      // R8/R5: quality 100 during encode
      ack_lat = 3;
      strobe(100);
      dmin = 999; dmax = 0; w0 = writes;
      run_frames(1);
      chk("R8", writes - w0 == NW, writes - w0, NW, "writes after quality change");
      chk("R5", dmax == 1, dmax, 1, "max entry at quality 100");
      chk("R5", dmin == 1, dmin, 1, "min entry at quality 100");
      // R9: same quality again
      strobe(100);
      w0 = writes;
      run_frames(2);
      chk("R9", writes == w0, writes - w0, 0, "writes after equal quality");
      // R12: done pulse during a load
      ack_lat = 1;
      spur_done_load = 1;
      strobe(10);
      w0 = writes;
      run_frames(1);
      chk("R12", writes - w0 == NW, writes - w0, NW, "writes with stray done");
      // R5: lowest quality saturates
      strobe(1);
      dmin = 999; dmax = 0;
      run_frames(1);
      chk("R5", dmin == 255, dmin, 255, "min entry at quality 1");
      // R11: strobe on the done edge
      ack_lat = 2;
      co_val = 25; co_mode = 1;
      w0 = writes;
      run_frames(1);
      chk("R11", writes - w0 == NW, writes - w0, NW, "strobe with done reloads");
      // R11: strobe on the start-decision edge
      co_val = 75; co_mode = 2;
      w0 = writes;
      run_frames(1);
      chk("R11", writes == w0, writes - w0, 0, "strobe at decision deferred");
      w0 = writes;
      run_frames(1);
      chk("R11", writes - w0 == NW, writes - w0, NW, "deferred reload at next boundary");
      // R8: strobe inside a load forces a second load
      strobe(30);
      w0 = writes;
      while (!loading_o) @(negedge clk);
      strobe(90);
      run_frames(1);
      chk("R8", writes - w0 == 2 * NW, writes - w0, 2 * NW, "strobe during load");
      // R6: frame not ready stalls the start
      frame_rdy_i = 1'b0;
      w0 = starts;
      repeat (enc_len + 20) @(negedge clk);
      chk("R6", starts == w0, starts - w0, 0, "no start without frame_rdy_i");
      frame_rdy_i = 1'b1;
      run_frames(1);
      chk("R6", starts == w0 + 1, starts - w0, 1, "start after frame_rdy_i");
      repeat (4) @(negedge clk);
      fin = 1;
      report();
   end
endmodule